// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a time-base enable, usually the system clock divided by four. A selectable prescaler divides that enable by 1, 4 or 16 before it reaches the counter. A comparator restarts the count when it equals a software-set period value. Each such restart is a match event.

Match events take two paths. The unscaled path gives a one-cycle pulse that other units can use as a PWM time base. The second path passes through a postscaler that divides by 1 to 16 and sets a sticky interrupt flag. The flag and a local enable together drive an interrupt request.

Software reaches the block through a small register port. The port covers the control word, the live count and the period value, plus a read-only flag view. The flag is cleared by a separate strobe.

Top module: `period_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter 0x00 and the period 0xFF; `flag_o`, `irq_o` and `pwm_tick_o` are 0.
- R2: On each counter increment the count rises by one. If the count equals the period at that increment, it returns to 0x00 and a match event occurs instead.
- R3: Control bits 1:0 choose how many enabled time-base cycles make one increment: 00 gives 1, 01 gives 4, and both 10 and 11 give 16.
- R4: The counter and prescaler advance only in cycles where `tick_i` is 1.
- R5: While control bit 2 (run) is 0, the counter and prescaler hold and no match occurs.
- R6: With control bits 6:3 holding N, the flag sets on every (N+1)-th match event.
- R7: `pwm_tick_o` is high for one cycle after every match, in the cycle when the count first reads 0x00. It does not depend on the postscaler.
- R8: `flag_o` stays 1 until a cycle with `flag_clr_i` = 1, and a set in the same cycle wins. `irq_o` is `flag_o` AND `irq_en_i`.
- R9: Register map, written when `wr_en_i` = 1:
  - address 0 is control, with bit 7 reading 0;
  - address 1 is the counter;
  - address 2 is the period;
  - address 3 reads the flag in bit 0.
  
  `rdata_o` shows the addressed register in the same cycle.
- R10: A write to the counter or to control clears the prescaler and postscaler counts and suppresses that cycle's increment. A period write leaves the count untouched.
- R11: A count above the period climbs to 0xFF and wraps to 0x00 without a match event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable (one system clock in four) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| irq_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request |
| pwm_tick_o | output | 1 | Unscaled match pulse for the PWM time base |

## Verification
A register write or `flag_clr_i` strobe takes effect at the next clock edge. Its result is visible one cycle after the stimulus. The first increment then follows D cycles later, where D is the prescale ratio, and every later increment comes another D cycles on.

`pwm_tick_o` and the flag change in the same cycle in which the count first shows 0x00. `rdata_o` and `irq_o` are combinational and are due in the stimulus cycle itself.

Each expected value is queued with the absolute cycle number at which it is due. It is compared in the middle of that cycle, so a result one cycle early or one cycle late fails.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PRE_W  = 4;
  localparam int unsigned POST_W = 4;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_PER  = 2'd2,
    ADDR_FLAG = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [POST_W-1:0] post_sel;
    logic              run;
    logic [1:0]        pre_sel;
  } ctrl_t;

  // terminal count for prescale select: 1, 4 or 16 ticks per increment
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = PRE_W'(0);
      2'b01:   pre_limit = PRE_W'(3);
      default: pre_limit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int unsigned W = PRE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       on_i,
  input  logic       tick_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       inc_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;
  logic         adv;

  assign lim   = W'(pre_limit(sel_i));
  assign adv   = on_i & tick_i & ~clr_i;
  assign inc_o = adv & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv)    cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  // R5
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_i && !clr_i) |=> $stable(cnt_q));
  // R4
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> tick_i);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q;

  assign match_o = inc_i & (cnt_q == period_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (we_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= match_o ? '0 : cnt_q + 1'b1;
  end

  // R2
  match_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !we_i) |=> (cnt_q == '0));
  // R11
  above_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > period_i) |-> !match_o);
endmodule

// File: rtl/tmr_postscale.sv
module tmr_postscale #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         match_i,
  input  logic         clr_i,
  input  logic [W-1:0] sel_i,
  output logic         evt_o
);
  logic [W-1:0] cnt_q;

  assign evt_o = match_i & ~clr_i & (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (match_i) cnt_q <= (cnt_q == sel_i) ? '0 : cnt_q + 1'b1;
  end

  // R6: select only changes with a clear, so the count never passes it
  post_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q <= sel_i));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
#(
  parameter int unsigned            DW      = DATA_W,
  parameter logic [DATA_W-1:0]      PER_RST = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  output logic          flag_o,
  output logic          irq_o,
  output logic          pwm_tick_o
);
  localparam int unsigned CTRL_W = POST_W + 1 + 2;

  ctrl_t         ctrl_q;
  logic [DW-1:0] per_q;
  logic [DW-1:0] cnt;
  logic          flag_q, pwm_q;
  logic          ctrl_we, cnt_we, per_we, scale_clr;
  logic          inc, match, evt;

  assign ctrl_we   = wr_en_i && (addr_i == ADDR_CTRL);
  assign cnt_we    = wr_en_i && (addr_i == ADDR_CNT);
  assign per_we    = wr_en_i && (addr_i == ADDR_PER);
  assign scale_clr = ctrl_we | cnt_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      per_q  <= PER_RST;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (per_we)  per_q  <= wdata_i;
    end
  end

  tmr_prescale #(.W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .on_i  (ctrl_q.run),
    .tick_i(tick_i),
    .clr_i (scale_clr),
    .sel_i (ctrl_q.pre_sel),
    .inc_o (inc)
  );

  tmr_count #(.W(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .we_i    (cnt_we),
    .wdata_i (wdata_i),
    .period_i(per_q),
    .cnt_o   (cnt),
    .match_o (match)
  );

  tmr_postscale #(.W(POST_W)) u_post (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .clr_i  (scale_clr),
    .sel_i  (ctrl_q.post_sel),
    .evt_o  (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      pwm_q <= match;
      if (evt)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = DW'({1'b0, ctrl_q});
      ADDR_CNT:  rdata_o = cnt;
      ADDR_PER:  rdata_o = per_q;
      default:   rdata_o = DW'(flag_q);
    endcase
  end

  assign flag_o     = flag_q;
  assign irq_o      = flag_q & irq_en_i;
  assign pwm_tick_o = pwm_q;

  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  // R7
  pwm_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> (pwm_tick_o && cnt == '0));
  // R10
  per_wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_we && !inc) |=> $stable(cnt));
endmodule

// File: tb/sim_period_timer.sv
module sim_period_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       flag_clr_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       flag_o, irq_o, pwm_tick_o;

  period_timer u0 (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .flag_clr_i, .irq_en_i, .flag_o, .irq_o, .pwm_tick_o
  );

  always #5 clk_i = ~clk_i;

  localparam int SEL_RD = 0, SEL_FLAG = 1, SEL_IRQ = 2, SEL_PWM = 3;

  typedef struct {
    int         due;
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare due items in mid-cycle
  always @(negedge clk_i) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        logic [7:0] act;
        case (q[i].sel)
          SEL_RD:   act = rdata_o;
          SEL_FLAG: act = {7'd0, flag_o};
          SEL_IRQ:  act = {7'd0, irq_o};
          default:  act = {7'd0, pwm_tick_o};
        endcase
        n_chk++;
        if (q[i].due != cyc || act !== q[i].exp) begin
          n_fail++;
          $display("FAIL %s cyc=%0d sel=%0d actual=%02h expected=%02h",
                   q[i].tag, cyc, q[i].sel, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic go();
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_at(int dly, int sel, logic [7:0] exp, string tag);
    item_t it;
    it.due = cyc + dly;
    it.sel = sel;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk_i);
    go();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    go();
    wr_en_i = 1'b0;
  endtask

  task automatic chk_rd(logic [1:0] a, logic [7:0] exp, string tag);
    addr_i = a;
    expect_at(0, SEL_RD, exp, tag);
    drain();
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    go();
    flag_clr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) go();
    rst_ni = 1'b1;
    go();

    // R1 reset state
    chk_rd(2'd0, 8'h00, "R1 ctrl");
    chk_rd(2'd2, 8'hFF, "R1 period");
    chk_rd(2'd1, 8'h00, "R1 counter");
    expect_at(0, SEL_FLAG, 8'h00, "R1 flag");
    expect_at(0, SEL_IRQ, 8'h00, "R1 irq");
    expect_at(0, SEL_PWM, 8'h00, "R1 pwm");
    drain();

    // R2 R7 R6: period 3, prescale 1:1, postscale 1:1
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h04);
    addr_i = 2'd1;
    expect_at(1, SEL_RD, 8'd1, "R2 count k1");
    expect_at(2, SEL_RD, 8'd2, "R2 count k2");
    expect_at(3, SEL_RD, 8'd3, "R2 count k3");
    expect_at(4, SEL_RD, 8'd0, "R2 restart k4");
    expect_at(5, SEL_RD, 8'd1, "R2 count k5");
    expect_at(3, SEL_PWM, 8'd0, "R7 pwm k3");
    expect_at(4, SEL_PWM, 8'd1, "R7 pwm k4");
    expect_at(5, SEL_PWM, 8'd0, "R7 pwm k5");
    expect_at(3, SEL_FLAG, 8'd0, "R6 flag k3");
    expect_at(4, SEL_FLAG, 8'd1, "R6 flag k4");
    drain();

    // R5 hold while stopped
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h05);
    addr_i = 2'd1;
    expect_at(0, SEL_RD, 8'h05, "R5 hold k0");
    expect_at(1, SEL_RD, 8'h05, "R5 hold k1");
    expect_at(6, SEL_RD, 8'h05, "R5 hold k6");
    expect_at(6, SEL_PWM, 8'd0, "R5 no match");
    drain();

    // R8 sticky flag, irq gating, clear
    expect_at(0, SEL_FLAG, 8'd1, "R8 sticky");
    expect_at(0, SEL_IRQ, 8'd0, "R8 irq masked");
    drain();
    irq_en_i = 1'b1;
    expect_at(0, SEL_IRQ, 8'd1, "R8 irq enabled");
    drain();
    clr_flag();
    expect_at(0, SEL_FLAG, 8'd0, "R8 cleared");
    expect_at(0, SEL_IRQ, 8'd0, "R8 irq cleared");
    drain();

    // R3 prescale 1:4
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    addr_i = 2'd1;
    expect_at(3, SEL_RD, 8'd0, "R3 div4 k3");
    expect_at(4, SEL_RD, 8'd1, "R3 div4 k4");
    expect_at(7, SEL_RD, 8'd1, "R3 div4 k7");
    expect_at(8, SEL_RD, 8'd2, "R3 div4 k8");
    drain();
    // R3 prescale encoding 11 -> 1:16
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    addr_i = 2'd1;
    expect_at(15, SEL_RD, 8'd0, "R3 div16 enc11 k15");
    expect_at(16, SEL_RD, 8'd1, "R3 div16 enc11 k16");
    drain();
    // R3 prescale encoding 10 -> 1:16
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h06);
    addr_i = 2'd1;
    expect_at(16, SEL_RD, 8'd1, "R3 div16 enc10 k16");
    expect_at(31, SEL_RD, 8'd1, "R3 div16 enc10 k31");
    expect_at(32, SEL_RD, 8'd2, "R3 div16 enc10 k32");
    drain();

    // R4 tick gating
    tick_i = 1'b0;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04);
    addr_i = 2'd1;
    expect_at(3, SEL_RD, 8'd1, "R4 tick k3");
    expect_at(4, SEL_RD, 8'd2, "R4 tick k4");
    expect_at(6, SEL_RD, 8'd2, "R4 tick k6");
    expect_at(7, SEL_RD, 8'd3, "R4 tick k7");
    for (int i = 0; i < 10; i++) begin
      tick_i = (i % 3 == 0);
      go();
    end
    tick_i = 1'b1;
    drain();

    // R6 postscale 1:3 with period 1
    wr(2'd0, 8'h00);
    clr_flag();
    wr(2'd2, 8'd1);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h14);
    addr_i = 2'd1;
    expect_at(2, SEL_RD, 8'd0, "R2 period1 restart");
    expect_at(2, SEL_PWM, 8'd1, "R7 pwm unscaled m1");
    expect_at(3, SEL_PWM, 8'd0, "R7 pwm low");
    expect_at(4, SEL_PWM, 8'd1, "R7 pwm unscaled m2");
    expect_at(4, SEL_FLAG, 8'd0, "R6 div3 m2");
    expect_at(5, SEL_FLAG, 8'd0, "R6 div3 k5");
    expect_at(6, SEL_FLAG, 8'd1, "R6 div3 m3");
    drain();

    // R11 count above period wraps without match
    wr(2'd0, 8'h00);
    clr_flag();
    wr(2'd2, 8'd2);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h04);
    addr_i = 2'd1;
    expect_at(1, SEL_RD, 8'hFF, "R11 climb");
    expect_at(2, SEL_RD, 8'h00, "R11 wrap");
    expect_at(2, SEL_PWM, 8'd0, "R11 wrap no pwm");
    expect_at(2, SEL_FLAG, 8'd0, "R11 wrap no flag");
    expect_at(4, SEL_RD, 8'd2, "R11 reach period");
    expect_at(5, SEL_RD, 8'd0, "R11 then restart");
    expect_at(5, SEL_PWM, 8'd1, "R11 match pwm");
    expect_at(5, SEL_FLAG, 8'd1, "R11 match flag");
    drain();

    // R10 period write keeps count
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h80);
    addr_i = 2'd1;
    expect_at(0, SEL_RD, 8'd1, "R10 per wr keep k1");
    expect_at(1, SEL_RD, 8'd2, "R10 per wr keep k2");
    drain();
    // R10 control write clears prescaler
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h05);
    go();
    go();
    wr(2'd0, 8'h05);
    addr_i = 2'd1;
    expect_at(1, SEL_RD, 8'd0, "R10 pre cleared k1");
    expect_at(3, SEL_RD, 8'd0, "R10 pre cleared k3");
    expect_at(4, SEL_RD, 8'd1, "R10 pre cleared k4");
    drain();

    // R9 register map
    wr(2'd0, 8'hFF);
    chk_rd(2'd0, 8'h7F, "R9 ctrl bit7 zero");
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h5A);
    chk_rd(2'd2, 8'h5A, "R9 period rw");
    chk_rd(2'd3, {7'd0, flag_o}, "R9 flag view");
    wr(2'd1, 8'hC3);
    chk_rd(2'd1, 8'hC3, "R9 counter rw");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule